// File: doc/BRIEF.md
# Strobed Serial Command Port

This block is the slave side of a three-wire serial link (strobe, clock, data in) plus an open-drain data-out line, for a display controller. All serial lines are asynchronous to the system clock. The block passes them through synchronizers and detects their edges on the system clock. Bytes arrive least significant bit first. The first byte of every strobe-low frame is a command; every later byte in the frame is data.

Commands set the display mode, the display on/off flag, the dimming code, the write address and the data operation. The data operation is one of: display write, LED write, key read or switch read. Display writes leave the block on a valid/ready stream toward the display memory. LED writes update a plain register. A read command loads the key or switch inputs into a shift register, which then drives the open-drain line one bit per falling serial clock edge.

Write stream rules: `wr_valid` stays high, with `wr_addr` and `wr_data` held, until the cycle in which `wr_ready` is high. The serial side cannot be stalled. A data byte that completes while a write is still waiting is discarded, and the address does not advance for it.

Top module: `strobe_serial_if`

## Requirements
- R1: After reset: `wr_valid`=0, `sdout_pull_low`=0, `disp_on`=0, `dim_code`=0, `disp_mode`=0, `led_out`=0. The address is 00H and the data operation is display write with auto-increment.
- R2: Data is taken on rising `sclk_in` edges while `strb_in` is low, least significant bit first. The first complete byte after `strb_in` falls is a command; each later complete byte in the same frame is data.
- R3: A command whose bits 7:6 are 00 loads bits 3:0 into `disp_mode`.
- R4: A command whose bits 7:6 are 10 loads bit 3 into `disp_on` and bits 2:0 into `dim_code`. These outputs change only after a command.
- R5: A command whose bits 7:6 are 11 loads bits 4:0 into the write address.
- R6: A command whose bits 7:6 are 01 sets the data operation. Bit 2 = 0 selects auto-increment and bit 2 = 1 selects a fixed address. Bits 1:0 select the operation: 00 display write, 01 LED write, 10 key read, 11 switch read.
- R7: With auto-increment, the address advances by one after each accepted display byte, and goes from 15H back to 00H. With a fixed address, it does not change.
- R8: Any edge on `strb_in` restarts the bit count, so a partial byte is discarded. `sclk_in` and `sdin_in` have no effect while `strb_in` is high.
- R9: In display-write mode, each data byte is offered on `wr_valid`/`wr_addr`/`wr_data` and held until `wr_ready`. A byte that completes while a write is pending is dropped, and the address does not advance for it.
- R10: After a key read command, each falling `sclk_in` edge presents the next bit of `key_in`, least significant bit first. A switch read does the same with `sw_in` padded with zeros to one byte. A 0 bit pulls low (`sdout_pull_low`=1) and a 1 bit releases the line. The line is released before the first falling edge, after the last bit, and on any `strb_in` edge.
- R11: In LED-write mode, bits 3:0 of each data byte are loaded into `led_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_in | input | 1 | Frame strobe, active low |
| sclk_in | input | 1 | Serial clock |
| sdin_in | input | 1 | Serial data in |
| sdout_pull_low | output | 1 | 1 = pull the open-drain output low |
| key_in | input | KEY_W (24) | Key matrix bits to read out |
| sw_in | input | SW_W (4) | Switch bits to read out |
| disp_mode | output | MODE_W (4) | Display mode field |
| disp_on | output | 1 | Display enable |
| dim_code | output | 3 | Dimming step |
| led_out | output | LED_W (4) | LED latch |
| wr_valid | output | 1 | Display write offered |
| wr_ready | input | 1 | Display memory accepts the write |
| wr_addr | output | ADDR_W (5) | Display write address |
| wr_data | output | 8 | Display write byte |

## Verification
A serial edge reaches the edge detectors after SYNC_STAGES+1 system clocks. Decoded command fields, the LED latch and `wr_valid` are then due one clock after the byte-complete pulse, and a new output bit is due one clock after the detected falling edge. That is at most five system clocks after the serial edge. The bench holds each serial level for eight system clocks and samples only at the end of that window, on the falling system-clock edge. Write-stream results are taken from a monitor that logs every valid-and-ready cycle.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  localparam logic [1:0] CLS_MODE = 2'b00;
  localparam logic [1:0] CLS_DATA = 2'b01;
  localparam logic [1:0] CLS_CTRL = 2'b10;
  localparam logic [1:0] CLS_ADDR = 2'b11;

  typedef enum logic [1:0] {
    OP_DISP = 2'b00,
    OP_LED  = 2'b01,
    OP_KEY  = 2'b10,
    OP_SW   = 2'b11
  } data_op_e;
endpackage

// File: rtl/ssi_sync.sv
module ssi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssi_rx.sv
module ssi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strb_q,
  input  logic       strb_edge,
  input  logic       sclk_rise,
  input  logic       sdin_q,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic       byte_is_cmd
);
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic       first_pending;
  logic       take;

  assign take = sclk_rise && !strb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt       <= '0;
      shreg         <= '0;
      first_pending <= 1'b1;
      byte_done     <= 1'b0;
      byte_val      <= '0;
      byte_is_cmd   <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (strb_edge) begin
        bit_cnt       <= '0;
        first_pending <= 1'b1;
      end else if (take) begin
        bit_cnt <= bit_cnt + 3'd1;
        shreg   <= {sdin_q, shreg[6:1]};
        if (bit_cnt == 3'd7) begin
          byte_done     <= 1'b1;
          byte_val      <= {sdin_q, shreg};
          byte_is_cmd   <= first_pending;
          first_pending <= 1'b0;
        end
      end
    end
  end

  // R8
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q |=> !byte_done);

  // R2
  cmd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && byte_is_cmd) |=> !(byte_done && byte_is_cmd));
endmodule

// File: rtl/ssi_decode.sv
module ssi_decode
  import ssi_pkg::*;
#(
  parameter int          ADDR_W    = 5,
  parameter logic [4:0]  LAST_ADDR = 5'h15,
  parameter int          MODE_W    = 4,
  parameter int          LED_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [7:0]        byte_val,
  input  logic              byte_is_cmd,
  output logic              load_key,
  output logic              load_sw,
  output logic [MODE_W-1:0] disp_mode,
  output logic              disp_on,
  output logic [2:0]        dim_code,
  output logic [LED_W-1:0]  led_out,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam logic [ADDR_W-1:0] WRAP_AT = ADDR_W'(LAST_ADDR);

  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] addr_next;
  logic              auto_inc;
  data_op_e          op;
  logic [1:0]        cls;
  logic              is_read_cmd;

  assign cls         = byte_val[7:6];
  assign addr_next   = (addr >= WRAP_AT) ? '0 : addr + 1'b1;
  assign is_read_cmd = byte_done && byte_is_cmd && (cls == CLS_DATA) && byte_val[1];
  assign load_key    = is_read_cmd && !byte_val[0];
  assign load_sw     = is_read_cmd &&  byte_val[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      auto_inc  <= 1'b1;
      op        <= OP_DISP;
      disp_mode <= '0;
      disp_on   <= 1'b0;
      dim_code  <= '0;
      led_out   <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (byte_done) begin
        if (byte_is_cmd) begin
          case (cls)
            CLS_MODE: disp_mode <= byte_val[MODE_W-1:0];
            CLS_DATA: begin
              auto_inc <= !byte_val[2];
              op       <= data_op_e'(byte_val[1:0]);
            end
            CLS_CTRL: begin
              disp_on  <= byte_val[3];
              dim_code <= byte_val[2:0];
            end
            default:  addr <= byte_val[ADDR_W-1:0];
          endcase
        end else begin
          case (op)
            OP_DISP: begin
              if (!wr_valid || wr_ready) begin
                wr_valid <= 1'b1;
                wr_addr  <= addr;
                wr_data  <= byte_val;
                if (auto_inc) addr <= addr_next;
              end
            end
            OP_LED:  led_out <= byte_val[LED_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R4
  ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> ($stable(disp_on) && $stable(dim_code)));
endmodule

// File: rtl/ssi_tx.sv
module ssi_tx #(
  parameter int KEY_W = 24,
  parameter int SW_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb_edge,
  input  logic             sclk_fall,
  input  logic             load_key,
  input  logic             load_sw,
  input  logic [KEY_W-1:0] key_in,
  input  logic [SW_W-1:0]  sw_in,
  output logic             pull_low
);
  localparam int TX_W  = (KEY_W > 8) ? KEY_W : 8;
  localparam int CNT_W = $clog2(TX_W + 1);
  localparam logic [CNT_W-1:0] KEY_LEN = CNT_W'(KEY_W);
  localparam logic [CNT_W-1:0] SW_LEN  = CNT_W'(8);

  logic [TX_W-1:0]  sh;
  logic [CNT_W-1:0] remaining;
  logic             armed;
  logic             on;
  logic             bitq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      remaining <= '0;
      armed     <= 1'b0;
      on        <= 1'b0;
      bitq      <= 1'b1;
    end else if (strb_edge) begin
      armed <= 1'b0;
      on    <= 1'b0;
      bitq  <= 1'b1;
    end else if (load_key || load_sw) begin
      sh        <= load_key ? TX_W'(key_in) : TX_W'(sw_in);
      remaining <= load_key ? KEY_LEN : SW_LEN;
      armed     <= 1'b1;
      on        <= 1'b0;
      bitq      <= 1'b1;
    end else if (sclk_fall && armed) begin
      if (remaining != '0) begin
        bitq      <= sh[0];
        sh        <= sh >> 1;
        remaining <= remaining - 1'b1;
        on        <= 1'b1;
      end else begin
        on    <= 1'b0;
        armed <= 1'b0;
        bitq  <= 1'b1;
      end
    end
  end

  assign pull_low = on && !bitq;

  // R10
  release_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_edge |=> !pull_low);

  // R10
  quiet_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_key || load_sw) |=> !pull_low);
endmodule

// File: rtl/strobe_serial_if.sv
module strobe_serial_if #(
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 5,
  parameter logic [4:0] LAST_ADDR   = 5'h15,
  parameter int         MODE_W      = 4,
  parameter int         LED_W       = 4,
  parameter int         KEY_W       = 24,
  parameter int         SW_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_in,
  input  logic              sclk_in,
  input  logic              sdin_in,
  output logic              sdout_pull_low,
  input  logic [KEY_W-1:0]  key_in,
  input  logic [SW_W-1:0]   sw_in,
  output logic [MODE_W-1:0] disp_mode,
  output logic              disp_on,
  output logic [2:0]        dim_code,
  output logic [LED_W-1:0]  led_out,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic [2:0] sync_q;
  logic       strb_q, sclk_q, sdin_q;
  logic       strb_prev, sclk_prev;
  logic       strb_edge, sclk_rise, sclk_fall;
  logic       byte_done, byte_is_cmd;
  logic [7:0] byte_val;
  logic       load_key, load_sw;

  ssi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({strb_in, sclk_in, sdin_in}),
    .q(sync_q)
  );

  assign {strb_q, sclk_q, sdin_q} = sync_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      strb_prev <= 1'b1;
      sclk_prev <= 1'b1;
    end else begin
      strb_prev <= strb_q;
      sclk_prev <= sclk_q;
    end

  assign strb_edge = strb_q ^ strb_prev;
  assign sclk_rise = sclk_q && !sclk_prev;
  assign sclk_fall = !sclk_q && sclk_prev && !strb_q;

  ssi_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .strb_q(strb_q), .strb_edge(strb_edge),
    .sclk_rise(sclk_rise), .sdin_q(sdin_q),
    .byte_done(byte_done), .byte_val(byte_val), .byte_is_cmd(byte_is_cmd)
  );

  ssi_decode #(
    .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR), .MODE_W(MODE_W), .LED_W(LED_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .byte_done(byte_done), .byte_val(byte_val), .byte_is_cmd(byte_is_cmd),
    .load_key(load_key), .load_sw(load_sw),
    .disp_mode(disp_mode), .disp_on(disp_on), .dim_code(dim_code),
    .led_out(led_out),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  ssi_tx #(.KEY_W(KEY_W), .SW_W(SW_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .strb_edge(strb_edge), .sclk_fall(sclk_fall),
    .load_key(load_key), .load_sw(load_sw),
    .key_in(key_in), .sw_in(sw_in),
    .pull_low(sdout_pull_low)
  );
endmodule

// File: tb/strobe_serial_if_tb_top.sv
module strobe_serial_if_tb_top;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strb_in = 1'b1, sclk_in = 1'b1, sdin_in = 1'b1;
  logic        sdout_pull_low;
  logic [23:0] key_in = '0;
  logic [3:0]  sw_in = '0;
  logic [3:0]  disp_mode;
  logic        disp_on;
  logic [2:0]  dim_code;
  logic [3:0]  led_out;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [4:0]  wr_addr;
  logic [7:0]  wr_data;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [4:0] log_addr [64];
  logic [7:0] log_data [64];
  int nlog = 0;

  always #10 clk = ~clk;

  strobe_serial_if dut_i (
    .clk(clk), .rst_n(rst_n), .strb_in(strb_in), .sclk_in(sclk_in), .sdin_in(sdin_in),
    .sdout_pull_low(sdout_pull_low), .key_in(key_in), .sw_in(sw_in),
    .disp_mode(disp_mode), .disp_on(disp_on), .dim_code(dim_code), .led_out(led_out),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk)
    if (rst_n && wr_valid && wr_ready && nlog < 64) begin
      log_addr[nlog] <= wr_addr;
      log_data[nlog] <= wr_data;
      nlog <= nlog + 1;
    end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic frame_open();
    @(negedge clk); strb_in = 1'b0; wait_h();
  endtask

  task automatic frame_close();
    @(negedge clk); strb_in = 1'b1; sclk_in = 1'b1; wait_h();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk_in = 1'b0; sdin_in = b[i]; wait_h();
      @(negedge clk); sclk_in = 1'b1; wait_h();
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic one_cmd(input logic [7:0] b);
    frame_open(); send_byte(b); frame_close();
  endtask

  task automatic read_bits(input logic [23:0] pat, input int n, input string tag);
    check({tag, " released before first fall"}, sdout_pull_low, 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk_in = 1'b0; wait_h();
      check(tag, sdout_pull_low, pat[i] ? 0 : 1);
      @(negedge clk); sclk_in = 1'b1; wait_h();
    end
    @(negedge clk); sclk_in = 1'b0; wait_h();
    check({tag, " released after last bit"}, sdout_pull_low, 0);
    @(negedge clk); sclk_in = 1'b1; wait_h();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 wr_valid", wr_valid, 0);
    check("R1 pull", sdout_pull_low, 0);
    check("R1 disp_on", disp_on, 0);
    check("R1 dim", dim_code, 0);
    check("R1 mode", disp_mode, 0);
    check("R1 led", led_out, 0);

    // R3 mode sweep
    for (int m = 0; m < 16; m++) begin
      one_cmd(8'(m));
      check("R3 disp_mode", disp_mode, m);
    end

    // R4 control sweep
    for (int v = 0; v < 16; v++) begin
      one_cmd(8'h80 | 8'(v));
      check("R4 disp_on", disp_on, v >> 3);
      check("R4 dim_code", dim_code, v & 7);
    end

    // R5 R7 R2 auto-increment with wrap
    one_cmd(8'h40);
    base = nlog;
    frame_open(); send_byte(8'hC0 | 8'h13);
    for (int k = 0; k < 4; k++) send_byte(8'h30 + 8'(k));
    frame_close();
    check("R7 write count", nlog - base, 4);
    for (int k = 0; k < 4; k++) begin
      check("R7 auto addr", log_addr[base+k], (8'h13 + k) % 8'h16);
      check("R2 data byte", log_data[base+k], 8'h30 + k);
    end

    // R6 fixed addressing
    one_cmd(8'h44);
    base = nlog;
    frame_open(); send_byte(8'hC5);
    for (int k = 0; k < 3; k++) send_byte(8'hA0 + 8'(k));
    frame_close();
    check("R6 fixed count", nlog - base, 3);
    for (int k = 0; k < 3; k++) check("R6 fixed addr", log_addr[base+k], 5);

    // R2 first byte of a new frame is a command, not data
    base = nlog;
    one_cmd(8'h8B);
    check("R2 cmd not written", nlog - base, 0);
    check("R2 cmd decoded", dim_code, 3);

    // R8 partial byte discarded
    frame_open(); send_bits(8'h85, 5); frame_close();
    check("R8 partial no effect", dim_code, 3);
    one_cmd(8'h86);
    check("R8 after partial", dim_code, 6);

    // R8 clock ignored while strobe high
    @(negedge clk); sdin_in = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); sclk_in = ~sclk_in; wait_h();
    end
    @(negedge clk); sclk_in = 1'b1; wait_h();
    check("R8 idle clocks no effect", dim_code, 6);
    one_cmd(8'h8D);
    check("R8 clean frame", dim_code, 5);
    check("R8 clean frame on", disp_on, 1);

    // R11 LED writes
    frame_open(); send_byte(8'h41); send_byte(8'hFA); frame_close();
    check("R11 led", led_out, 4'hA);
    frame_open(); send_byte(8'h41); send_byte(8'h05); frame_close();
    check("R11 led second", led_out, 4'h5);

    // R10 key read, two patterns
    key_in = 24'hA5C31E;
    frame_open(); send_byte(8'h42); read_bits(24'hA5C31E, 24, "R10 key"); frame_close();
    key_in = 24'h0F00F0;
    frame_open(); send_byte(8'h42); read_bits(24'h0F00F0, 24, "R10 key2"); frame_close();
    sw_in = 4'b1010;
    frame_open(); send_byte(8'h43); read_bits(24'h00000A, 8, "R10 sw"); frame_close();
    // R10 strobe edge stops a read
    key_in = 24'h000000;
    frame_open(); send_byte(8'h42);
    @(negedge clk); sclk_in = 1'b0; wait_h();
    check("R10 mid read low", sdout_pull_low, 1);
    frame_close();
    check("R10 strobe release", sdout_pull_low, 0);

    // R9 back-pressure
    one_cmd(8'h40);
    base = nlog;
    @(negedge clk); wr_ready = 1'b0;
    frame_open(); send_byte(8'hC2); send_byte(8'h11); send_byte(8'h22); frame_close();
    check("R9 held valid", wr_valid, 1);
    check("R9 held data", wr_data, 8'h11);
    check("R9 held addr", wr_addr, 2);
    @(negedge clk); wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 one accepted", nlog - base, 1);
    frame_open(); send_byte(8'h40); send_byte(8'h33); frame_close();
    check("R9 next addr", log_addr[base+1], 3);
    check("R9 next data", log_data[base+1], 8'h33);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule